// File: doc/BRIEF.md
# APB Secondary Interrupt Aggregator

This block gathers a configurable number of level-sensitive interrupt lines, from 2 to 64, and reduces them to one active-high request for a primary interrupt controller. Each line has its own enable bit and its own mask bit. A line reaches the output only while it is high, enabled and not masked. The per-line controls are split into two 32-bit banks. Lines 0 to 31 occupy bits 0 to 31 of the lower bank. Lines 32 to 63 occupy bits 0 to 31 of the upper bank.

Software reaches the block through a zero-wait-state APB slave port. It reads a pair of read-only pending-status words to find the lines that need service, and handles them from the lowest index upward. Control bits for lines that are not built have no storage and read as zero. Software can therefore write all ones to the enable words and take the highest bit that reads back as the built line count. Raw lines pass through a two-flop synchroniser before any gating.

Top module: `apb_irq_aggregator`

## Requirements
- R1: Synchronous reset clears every enable and mask bit, so the enable and mask words read 0 and `irq_o` is low after reset.
- R2: Enable words are at offset 0x000 (lines 0-31, bit n = line n) and 0x004 (lines 32-63, bit n = line 32+n). A 1 enables the line. Written values read back at the same offsets.
- R3: Mask words are at offset 0x008 (low) and 0x00C (high), with the same bit layout as the enable words. A 1 masks the line and a 0 unmasks it. A masked line shows no pending status and cannot raise `irq_o`.
- R4: Enable and mask bits for lines at or above NUM_SRC always read 0, even after all ones has been written to them.
- R5: Pending-status words at 0x030 (low) and 0x034 (high) show, for each line, the synchronised line AND its enable bit AND NOT its mask bit.
- R6: `irq_o` is the OR of all pending-status bits, registered once. It changes one clock edge after the status changes.
- R7: `pready` is always 1 and `pslverr` is always 0.
- R8: Reads of any offset other than the six listed return 0. Writes to such offsets change no enable or mask bit.
- R9: The pending-status words are read-only. Writing to 0x030 or 0x034 changes neither the status nor any enable or mask bit.
- R10: A change on a raw line appears in the pending status after exactly two rising clock edges, and on `irq_o` after three.
- R11: Lines are level-sensitive. When a line drops, its pending status clears after the synchroniser delay, and `irq_o` falls if no other line is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1, read when 0 |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid during the access phase |
| pready | output | 1 | Transfer ready, tied high |
| pslverr | output | 1 | Transfer error, tied low |
| src_i | input | NUM_SRC | Raw level-sensitive interrupt lines |
| irq_o | output | 1 | Combined active-high request |

## Verification
The hardest behaviour to reach is a line in the upper bank that sits above the built count: no input can drive it, so it is reached only through register writes. The bench builds the block with 40 lines and writes all ones to both banks. This places the built/unbuilt boundary in the middle of the upper word, and the readback must show 0xFF. The synchroniser latency is checked edge by edge: a raw line is raised at a falling edge, and `irq_o` is sampled after the second and after the third rising edge. Random enable, mask and line patterns follow. They cover combinations where enabled, masked and idle lines mix across both banks.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 12;
    localparam int MAX_SRC = 64;

    localparam logic [ADDR_W-1:0] OFF_EN_LO = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_EN_HI = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_MK_LO = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_MK_HI = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_ST_LO = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_ST_HI = 12'h034;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN_LO,
        SEL_EN_HI,
        SEL_MK_LO,
        SEL_MK_HI,
        SEL_ST_LO,
        SEL_ST_HI
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_EN_LO: return SEL_EN_LO;
            OFF_EN_HI: return SEL_EN_HI;
            OFF_MK_LO: return SEL_MK_LO;
            OFF_MK_HI: return SEL_MK_HI;
            OFF_ST_LO: return SEL_ST_LO;
            OFF_ST_HI: return SEL_ST_HI;
            default:   return SEL_NONE;
        endcase
    endfunction

    // Bits of one 32-bit bank that correspond to built lines
    function automatic logic [REG_W-1:0] bank_impl(input int n, input int bank);
        logic [REG_W-1:0] r;
        for (int b = 0; b < REG_W; b++) r[b] = ((bank * REG_W + b) < n);
        return r;
    endfunction

endpackage

// File: rtl/ictl_sync.sv
module ictl_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/ictl_regbank.sv
module ictl_regbank
    import ictl_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [REG_W-1:0]   wdata,
    output logic [NUM_SRC-1:0] enable,
    output logic [NUM_SRC-1:0] mask
);
    // One flop pair per built line; unbuilt lines have no storage at all
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
        localparam int BANK = i / REG_W;
        localparam int BITN = i % REG_W;
        localparam reg_sel_e EN_SEL = (BANK == 0) ? SEL_EN_LO : SEL_EN_HI;
        localparam reg_sel_e MK_SEL = (BANK == 0) ? SEL_MK_LO : SEL_MK_HI;

        always_ff @(posedge clk) begin
            if (rst) begin
                enable[i] <= 1'b0;
                mask[i]   <= 1'b0;
            end else if (req.wr) begin
                if (req.sel == EN_SEL) enable[i] <= wdata[BITN];
                if (req.sel == MK_SEL) mask[i]   <= wdata[BITN];
            end
        end
    end
endmodule

// File: rtl/ictl_combine.sv
module ictl_combine #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] line,
    input  logic [NUM_SRC-1:0] enable,
    input  logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] status,
    output logic               irq
);
    assign status = line & enable & ~mask;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |status;
    end
endmodule

// File: rtl/apb_irq_aggregator.sv
module apb_irq_aggregator
    import ictl_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [REG_W-1:0]     pwdata,
    output logic [REG_W-1:0]     prdata,
    output logic                 pready,
    output logic                 pslverr,
    input  logic [NUM_SRC-1:0]   src_i,
    output logic                 irq_o
);
    localparam int PAD = MAX_SRC - NUM_SRC;

    bus_req_t           req;
    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] mk_q;
    logic [NUM_SRC-1:0] status;
    logic [MAX_SRC-1:0] en_w, mk_w, st_w;

    assign req.sel = decode_addr(paddr);
    assign req.wr  = psel & penable & pwrite;

    ictl_sync #(.W(NUM_SRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_i),
        .q   (src_sync)
    );

    ictl_regbank #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .wdata  (pwdata),
        .enable (en_q),
        .mask   (mk_q)
    );

    ictl_combine #(.NUM_SRC(NUM_SRC)) u_comb (
        .clk    (clk),
        .rst    (rst),
        .line   (src_sync),
        .enable (en_q),
        .mask   (mk_q),
        .status (status),
        .irq    (irq_o)
    );

    // Zero-extend to the full 64-line view
    if (PAD > 0) begin : g_pad
        assign en_w = {{PAD{1'b0}}, en_q};
        assign mk_w = {{PAD{1'b0}}, mk_q};
        assign st_w = {{PAD{1'b0}}, status};
    end else begin : g_nopad
        assign en_w = en_q;
        assign mk_w = mk_q;
        assign st_w = status;
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (req.sel)
                SEL_EN_LO: prdata = en_w[REG_W-1:0];
                SEL_EN_HI: prdata = en_w[MAX_SRC-1:REG_W];
                SEL_MK_LO: prdata = mk_w[REG_W-1:0];
                SEL_MK_HI: prdata = mk_w[MAX_SRC-1:REG_W];
                SEL_ST_LO: prdata = st_w[REG_W-1:0];
                SEL_ST_HI: prdata = st_w[MAX_SRC-1:REG_W];
                default:   prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: rtl/ictl_checker.sv
module ictl_checker
    import ictl_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [ADDR_W-1:0]  paddr,
    input logic [REG_W-1:0]   prdata,
    input logic [NUM_SRC-1:0] src_i,
    input logic [NUM_SRC-1:0] src_sync,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] mk_q,
    input logic               irq_o
);
    localparam logic [REG_W-1:0] HI_IMPL = bank_impl(NUM_SRC, 1);

    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst)            cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    logic unmapped;
    assign unmapped = (paddr != OFF_EN_LO) && (paddr != OFF_EN_HI) &&
                      (paddr != OFF_MK_LO) && (paddr != OFF_MK_HI) &&
                      (paddr != OFF_ST_LO) && (paddr != OFF_ST_HI);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !irq_o);

    a_r4_unbuilt_high_zero: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && (paddr == OFF_EN_HI || paddr == OFF_MK_HI))
            |-> ((prdata & ~HI_IMPL) == '0));

    a_r6_irq_follows_status: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1) |-> (irq_o == $past(|(src_sync & en_q & ~mk_q))));

    a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && unmapped) |-> (prdata == '0));

    a_r8_unmapped_write_inert: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && unmapped) |=> ($stable(en_q) && $stable(mk_q)));

    a_r9_status_write_inert: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && (paddr == OFF_ST_LO || paddr == OFF_ST_HI))
            |=> ($stable(en_q) && $stable(mk_q)));

    a_r10_two_stage_delay: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> (src_sync == $past(src_i, 2)));
endmodule

bind apb_irq_aggregator ictl_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .prdata   (prdata),
    .src_i    (src_i),
    .src_sync (src_sync),
    .en_q     (en_q),
    .mk_q     (mk_q),
    .irq_o    (irq_o)
);

// File: tb/apb_irq_aggregator_tb.sv
module apb_irq_aggregator_tb;
    localparam int CLK_P = 10;
    localparam int N     = 40;
    localparam logic [63:0] IMPL = (64'd1 << N) - 64'd1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [N-1:0] src = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] m_en = '0, m_mk = '0;

    always #(CLK_P/2) clk = ~clk;

    apb_irq_aggregator #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .src_i(src), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [63:0] exp_status();
        return {{(64-N){1'b0}}, src} & m_en & ~m_mk & IMPL;
    endfunction

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        case (a)
            12'h000: m_en[31:0]  = d;
            12'h004: m_en[63:32] = d;
            12'h008: m_mk[31:0]  = d;
            12'h00C: m_mk[63:32] = d;
            default: ;
        endcase
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #(CLK_P/4);
        d = prdata;
        check("R7 pready", {63'd0, pready}, 64'd1);
        check("R7 pslverr", {63'd0, pslverr}, 64'd0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic check_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        apb_rd(a, d);
        check(req, {32'd0, d}, {32'd0, exp});
    endtask

    task automatic check_status(input string req);
        logic [63:0] e;
        e = exp_status();
        check_reg(req, 12'h030, e[31:0]);
        check_reg(req, 12'h034, e[63:32]);
        check({req, " irq"}, {63'd0, irq_o}, {63'd0, |e});
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);

        // R1 reset state
        check("R1 irq", {63'd0, irq_o}, 64'd0);
        check_reg("R1 en_lo", 12'h000, 32'h0);
        check_reg("R1 en_hi", 12'h004, 32'h0);
        check_reg("R1 mk_lo", 12'h008, 32'h0);
        check_reg("R1 mk_hi", 12'h00C, 32'h0);

        // R4 size probe, R2/R3 readback
        apb_wr(12'h000, 32'hFFFF_FFFF);
        apb_wr(12'h004, 32'hFFFF_FFFF);
        apb_wr(12'h008, 32'hFFFF_FFFF);
        apb_wr(12'h00C, 32'hFFFF_FFFF);
        check_reg("R2 en_lo", 12'h000, 32'hFFFF_FFFF);
        check_reg("R4 en_hi", 12'h004, 32'h0000_00FF);
        check_reg("R3 mk_lo", 12'h008, 32'hFFFF_FFFF);
        check_reg("R4 mk_hi", 12'h00C, 32'h0000_00FF);
        apb_wr(12'h008, 32'h0);
        apb_wr(12'h00C, 32'h0);
        apb_wr(12'h000, 32'h0);
        apb_wr(12'h004, 32'h0);

        // R10 latency: line 3 enabled
        apb_wr(12'h000, 32'h0000_0008);
        @(negedge clk);
        src[3] = 1'b1;
        @(negedge clk);
        check("R10 irq after 1 edge", {63'd0, irq_o}, 64'd0);
        @(negedge clk);
        check("R10 irq after 2 edges", {63'd0, irq_o}, 64'd0);
        @(negedge clk);
        check("R10 R6 irq after 3 edges", {63'd0, irq_o}, 64'd1);
        check_status("R5 line3");

        // R11 level-sensitive drop
        src[3] = 1'b0;
        wait_cyc(3);
        check("R11 irq drops", {63'd0, irq_o}, 64'd0);
        check_status("R11 status clear");

        // R3 mask blocks, unmask restores
        src[3] = 1'b1;
        apb_wr(12'h008, 32'h0000_0008);
        wait_cyc(3);
        check_status("R3 masked");
        apb_wr(12'h008, 32'h0);
        wait_cyc(2);
        check_status("R3 unmasked");

        // R2 high bank: line 35 is bit 3 of the high word
        src = '0;
        src[35] = 1'b1;
        apb_wr(12'h004, 32'h0000_0008);
        wait_cyc(3);
        check_status("R2 high line35");

        // R9 status read-only
        apb_wr(12'h030, 32'h0);
        apb_wr(12'h034, 32'hFFFF_FFFF);
        check_status("R9 status after write");
        check_reg("R9 en_hi kept", 12'h004, 32'h0000_0008);
        check_reg("R9 mk_hi kept", 12'h00C, 32'h0);

        // R8 unmapped offsets
        apb_wr(12'h010, 32'hFFFF_FFFF);
        apb_wr(12'h001, 32'hFFFF_FFFF);
        check_reg("R8 read 0x010", 12'h010, 32'h0);
        check_reg("R8 read 0x031", 12'h031, 32'h0);
        check_reg("R8 en_lo kept", 12'h000, 32'h0000_0008);
        check_reg("R8 mk_lo kept", 12'h008, 32'h0);

        // Random mix across both banks
        for (int it = 0; it < 40; it++) begin
            logic [63:0] r;
            apb_wr(12'h000, $urandom());
            apb_wr(12'h004, $urandom());
            apb_wr(12'h008, $urandom() & $urandom());
            apb_wr(12'h00C, $urandom() & $urandom());
            r = {$urandom(), $urandom()};
            @(negedge clk);
            src = r[N-1:0];
            wait_cyc(3);
            check_status("R5 R6 random");
        end

        finish_run();
    end
endmodule